// File: doc/BRIEF.md
# Parallel Test Mode Compressor

This block is the device-side control for a compressed test mode in a four-bit-wide dynamic memory. It watches the three active-low strobes (row strobe, column strobe, write enable) on a sampling clock. The order in which they fall selects the next mode. A row strobe that falls while the column strobe and write enable are both already low puts the device into test mode. A plain column-before-row refresh, or a row cycle with no column strobe in it, takes the device back out.

In test mode, the two lowest column address bits are ignored. A write sends each data bit into the four cells of its I/O that differ only in those two bits. A read does not return stored data. Instead, each I/O reports a verdict: high when its four cells agree, low when they do not. Outside test mode the block is an ordinary single-cell read and write path with extended data-out behaviour. A small behavioural storage array is included so that the whole path can be exercised.

Top module: `ptm_core`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `test_mode`, `dout_en` and `dout` are all zero.
- R2: A high-to-low `ras_n` transition sampled while `cas_n` and `we_n` are both low sets `test_mode`, which is visible one clock later.
- R3: A high-to-low `ras_n` transition sampled with `cas_n` low and `we_n` high clears `test_mode`. `we_n` is sampled only at that row edge, so a later change of `we_n` during the same row cycle does not alter the outcome.
- R4: A row cycle in which no `cas_n` fall is sampled while `ras_n` is low clears `test_mode` one clock after `ras_n` returns high. This includes a `cas_n` fall that lands in the same sample as the `ras_n` rise, and no array access takes place for it.
- R5: Normal read cycles and repeated test-entry cycles performed while in test mode leave `test_mode` set.
- R6: In normal mode, a `cas_n` fall with `we_n` low writes `din` into the single cell at (latched row, column address). With `we_n` high, the same cell is read onto `dout`, and no other cell is touched.
- R7: In test mode, a write stores `din` into the four cells of the addressed row whose column addresses differ only in bits [1:0]. The values of those two bits have no effect.
- R8: In test mode, a read sets `dout[i]` to 1 when the four cells of I/O `i` in the addressed group are all equal, and to 0 otherwise.
- R9: `dout_en` rises one clock after a read `cas_n` fall. It stays high through a `cas_n` return to high and falls one clock after `ras_n` rises. A write cycle leaves it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W (4) | Multiplexed row/column address |
| din | input | DQ_W (4) | Write data |
| dout | output | DQ_W (4) | Read data or per-I/O verdict |
| dout_en | output | 1 | Read data valid / output driven |
| test_mode | output | 1 | Test mode currently active |

## Verification
The sharpest collision is a row strobe rising in the very sample where the column strobe falls. This one sample decides both whether the cycle counts as refresh-only (and so leaves test mode) and whether an array access happens. The bench drives both edges on the same clock, then checks that the mode drops, that `dout_en` stays low, and that the stored cells are unchanged when read back in normal mode. A second overlap also matters: a test-mode write and the verdict read share a four-cell group. So quads are made unequal on purpose by single normal-mode writes between test-mode sessions, and the verdict is compared against a bench model of the array.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
    localparam int LANES     = 4;
    localparam int LANE_BITS = 2;

    typedef enum logic [1:0] {
        CYC_IDLE   = 2'd0,
        CYC_ACCESS = 2'd1,
        CYC_CBR    = 2'd2,
        CYC_WCBR   = 2'd3
    } cyc_kind_t;
endpackage

// File: rtl/ptm_strobe_ctl.sv
module ptm_strobe_ctl
    import ptm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output logic row_load,
    output logic ras_rise,
    output logic acc_strobe,
    output logic test_mode
);
    typedef struct packed {
        logic      ras_p;
        logic      cas_p;
        cyc_kind_t kind;
        logic      cas_seen;
        logic      tmode;
    } ctl_t;

    ctl_t q, d;
    logic ras_fall, cas_fall;

    always_comb begin
        d        = q;
        ras_fall = q.ras_p & ~ras_n;
        ras_rise = ~q.ras_p & ras_n;
        cas_fall = q.cas_p & ~cas_n;
        row_load = ras_fall & cas_n;
        acc_strobe = cas_fall & ~ras_n & (q.kind == CYC_ACCESS);

        d.ras_p = ras_n;
        d.cas_p = cas_n;

        if (ras_fall) begin
            d.cas_seen = 1'b0;
            if (!cas_n) begin
                d.kind  = we_n ? CYC_CBR : CYC_WCBR;
                d.tmode = ~we_n;
            end else begin
                d.kind = CYC_ACCESS;
            end
        end else if (acc_strobe) begin
            d.cas_seen = 1'b1;
        end

        if (ras_rise) begin
            if (q.kind == CYC_ACCESS && !q.cas_seen)
                d.tmode = 1'b0;
            d.kind     = CYC_IDLE;
            d.cas_seen = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ras_p    <= 1'b1;
            q.cas_p    <= 1'b1;
            q.kind     <= CYC_IDLE;
            q.cas_seen <= 1'b0;
            q.tmode    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign test_mode = q.tmode;

    // R2: entry order sets the mode
    a_r2_wcbr_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ras_p && !ras_n && !cas_n && !we_n) |=> test_mode);

    // R3: plain CBR leaves the mode
    a_r3_cbr_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ras_p && !ras_n && !cas_n && we_n) |=> !test_mode);

    // R4: row cycle without column strobe leaves the mode
    a_r4_rasonly_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_rise && q.kind == CYC_ACCESS && !q.cas_seen) |=> !test_mode);
endmodule

// File: rtl/ptm_store.sv
module ptm_store
    import ptm_pkg::*;
#(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 4,
    parameter int DQ_W     = 4
) (
    input  logic                      clk,
    input  logic [ROW_BITS-1:0]       row,
    input  logic [COL_BITS-3:0]       grp,
    input  logic                      wr,
    input  logic [LANES-1:0]          lane_mask,
    input  logic [DQ_W-1:0]           wdata,
    output logic [LANES*DQ_W-1:0]     rquad
);
    localparam int GRP_BITS = COL_BITS - LANE_BITS;
    localparam int DEPTH    = (1 << ROW_BITS) * (1 << GRP_BITS);
    localparam int IDX_W    = ROW_BITS + GRP_BITS;

    logic [LANES*DQ_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]      idx;

    assign idx   = {row, grp};
    assign rquad = mem[idx];

    always_ff @(posedge clk) begin
        if (wr) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_mask[l])
                    mem[idx][l*DQ_W +: DQ_W] <= wdata;
            end
        end
    end
endmodule

// File: rtl/ptm_compress.sv
module ptm_compress
    import ptm_pkg::*;
#(
    parameter int DQ_W = 4
) (
    input  logic [LANES*DQ_W-1:0] quad,
    output logic [DQ_W-1:0]       verdict
);
    for (genvar i = 0; i < DQ_W; i++) begin : g_io
        logic [LANES-1:0] cells;
        always_comb begin
            for (int l = 0; l < LANES; l++)
                cells[l] = quad[l*DQ_W + i];
        end
        assign verdict[i] = (&cells) | ~(|cells);
    end
endmodule

// File: rtl/ptm_core.sv
module ptm_core
    import ptm_pkg::*;
#(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 4,
    parameter int DQ_W     = 4,
    localparam int ADDR_W  = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   din,
    output logic [DQ_W-1:0]   dout,
    output logic              dout_en,
    output logic              test_mode
);
    typedef struct packed {
        logic [ROW_BITS-1:0] row;
        logic [DQ_W-1:0]     dout;
        logic                en;
    } core_t;

    core_t q, d;

    logic                  row_load, ras_rise, acc_strobe;
    logic [LANE_BITS-1:0]  col_lo;
    logic [COL_BITS-3:0]   col_grp;
    logic [LANES-1:0]      lane_mask;
    logic                  st_wr;
    logic [LANES*DQ_W-1:0] rquad;
    logic [DQ_W-1:0]       verdict;
    logic [DQ_W-1:0]       lane_data;

    ptm_strobe_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .row_load   (row_load),
        .ras_rise   (ras_rise),
        .acc_strobe (acc_strobe),
        .test_mode  (test_mode)
    );

    assign col_lo  = addr[LANE_BITS-1:0];
    assign col_grp = addr[COL_BITS-1:LANE_BITS];

    always_comb begin
        lane_mask = '0;
        if (test_mode) lane_mask = '1;
        else           lane_mask[col_lo] = 1'b1;
    end

    assign st_wr = acc_strobe & ~we_n;

    ptm_store #(
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS),
        .DQ_W     (DQ_W)
    ) u_store (
        .clk       (clk),
        .row       (q.row),
        .grp       (col_grp),
        .wr        (st_wr),
        .lane_mask (lane_mask),
        .wdata     (din),
        .rquad     (rquad)
    );

    ptm_compress #(.DQ_W(DQ_W)) u_cmp (
        .quad    (rquad),
        .verdict (verdict)
    );

    assign lane_data = rquad[col_lo*DQ_W +: DQ_W];

    always_comb begin
        d = q;
        if (row_load) d.row = addr[ROW_BITS-1:0];
        if (ras_rise) d.en = 1'b0;
        if (acc_strobe) begin
            if (we_n) begin
                d.en   = 1'b1;
                d.dout = test_mode ? verdict : lane_data;
            end else begin
                d.en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout    = q.dout;
    assign dout_en = q.en;

    // R9: output only enabled inside a row cycle
    a_r9_en_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(!ras_n));

    // R9: extended data-out holds its value between column strobes
    a_r9_dout_held: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && $past(dout_en) && $past(cas_n)) |-> $stable(dout));
endmodule

// File: tb/tb_ptm_core.sv
module tb_ptm_core;
    localparam int ROWS = 16;
    localparam int COLS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [3:0] addr = '0, din = '0;
    logic [3:0] dout;
    logic       dout_en, test_mode;

    int vectors = 0, errors = 0;
    bit done = 0;
    logic [3:0] mdl [ROWS][COLS];
    bit tm_mdl = 0;

    always #10 clk = ~clk;

    ptm_core dut (.clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
                  .we_n(we_n), .addr(addr), .din(din), .dout(dout),
                  .dout_en(dout_en), .test_mode(test_mode));

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_read(int r, int c);
        logic [3:0] v;
        int g;
        if (!tm_mdl) return mdl[r][c];
        g = c & ~3;
        for (int i = 0; i < 4; i++) begin
            logic [3:0] b;
            for (int l = 0; l < 4; l++) b[l] = mdl[r][g+l][i];
            v[i] = (&b) | ~(|b);
        end
        return v;
    endfunction

    task automatic nclk(); @(negedge clk); endtask

    task automatic wr_cyc(int r, int c, logic [3:0] dv);
        nclk(); addr = 4'(r); ras_n = 0;
        nclk(); addr = 4'(c); we_n = 0; din = dv;
        nclk(); cas_n = 0;
        nclk(); chk("R9 write keeps dout_en low", {3'b0, dout_en}, 4'h0);
        cas_n = 1; we_n = 1;
        nclk(); ras_n = 1;
        nclk();
        if (tm_mdl) for (int l = 0; l < 4; l++) mdl[r][(c & ~3) + l] = dv;
        else        mdl[r][c] = dv;
    endtask

    task automatic rd_cyc(int r, int c, string req);
        logic [3:0] e;
        e = exp_read(r, c);
        nclk(); addr = 4'(r); ras_n = 0;
        nclk(); addr = 4'(c); we_n = 1;
        nclk(); cas_n = 0;
        nclk(); chk("R9 dout_en after read", {3'b0, dout_en}, 4'h1);
        chk(req, dout, e);
        cas_n = 1;
        nclk(); chk("R9 dout_en held after cas high", {3'b0, dout_en}, 4'h1);
        chk("R9 dout held", dout, e);
        ras_n = 1;
        nclk(); chk("R9 dout_en low after ras high", {3'b0, dout_en}, 4'h0);
    endtask

    task automatic cbr_cyc(bit wcbr, bit flip_we);
        nclk(); cas_n = 0; we_n = wcbr ? 1'b0 : 1'b1;
        nclk(); ras_n = 0;
        nclk(); if (flip_we) we_n = ~we_n;
        nclk(); we_n = 1; cas_n = 1;
        nclk(); ras_n = 1;
        nclk();
        tm_mdl = wcbr;
    endtask

    task automatic ras_only(int r);
        nclk(); addr = 4'(r); ras_n = 0;
        nclk();
        nclk(); ras_n = 1;
        nclk();
        tm_mdl = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int r, c;
        logic [3:0] dv;
        void'($urandom(32'd20240611));
        repeat (3) nclk();
        // R1: reset state
        chk("R1 test_mode in reset", {3'b0, test_mode}, 4'h0);
        chk("R1 dout_en in reset", {3'b0, dout_en}, 4'h0);
        chk("R1 dout in reset", dout, 4'h0);
        rst_n = 1;
        nclk();
        chk("R1 test_mode after reset", {3'b0, test_mode}, 4'h0);
        chk("R1 dout after reset", dout, 4'h0);

        // R6: fill array in normal mode, random read-back
        for (int rr = 0; rr < ROWS; rr++)
            for (int cc = 0; cc < COLS; cc++)
                wr_cyc(rr, cc, 4'($urandom));
        for (int k = 0; k < 40; k++)
            rd_cyc($urandom % ROWS, $urandom % COLS, "R6 normal read");

        // R2: enter test mode
        cbr_cyc(1, 0);
        chk("R2 wcbr enters", {3'b0, test_mode}, 4'h1);
        // R8: verdict on random (mostly unequal) quads
        for (int k = 0; k < 20; k++)
            rd_cyc($urandom % ROWS, $urandom % COLS, "R8 verdict random");
        // R7: test writes, column low bits random
        for (int k = 0; k < 30; k++) begin
            r = $urandom % ROWS; c = $urandom % COLS; dv = 4'($urandom);
            wr_cyc(r, c, dv);
            rd_cyc(r, c ^ ($urandom % 4), "R8 verdict after test write");
        end
        // R5: repeated entry and reads keep mode
        cbr_cyc(1, 0);
        chk("R5 repeated wcbr keeps mode", {3'b0, test_mode}, 4'h1);
        rd_cyc(3, 5, "R8 verdict");
        chk("R5 read keeps mode", {3'b0, test_mode}, 4'h1);

        // R7: write then verify four cells individually in normal mode
        wr_cyc(7, 9, 4'hA);
        // R3: CBR exit, WE flipped low after row edge must not matter
        cbr_cyc(0, 1);
        chk("R3 cbr exits", {3'b0, test_mode}, 4'h0);
        for (int l = 0; l < 4; l++) rd_cyc(7, 8 + l, "R7 quad replicated");

        // R8: break one cell, verdict low only on the differing bit
        wr_cyc(7, 10, 4'hB);
        cbr_cyc(1, 0);
        rd_cyc(7, 8, "R8 mixed quad");
        chk("R8 mixed quad bit pattern", exp_read(7, 8), 4'hE);

        // R4: RAS-only exit
        ras_only(2);
        chk("R4 ras-only exits", {3'b0, test_mode}, 4'h0);

        // R4: coincident ras rise and cas fall counts as ras-only, no access
        cbr_cyc(1, 0);
        chk("R2 re-entry", {3'b0, test_mode}, 4'h1);
        nclk(); addr = 4'd7; ras_n = 0;
        nclk(); addr = 4'd8; we_n = 0; din = 4'h5;
        nclk(); ras_n = 1; cas_n = 0;
        nclk(); chk("R4 coincident edge exits", {3'b0, test_mode}, 4'h0);
        chk("R4 coincident edge no enable", {3'b0, dout_en}, 4'h0);
        cas_n = 1; we_n = 1;
        nclk();
        tm_mdl = 0;
        rd_cyc(7, 8, "R4 coincident edge no write");

        // R6: random normal mix after all modes
        for (int k = 0; k < 30; k++) begin
            r = $urandom % ROWS; c = $urandom % COLS;
            if ($urandom % 2) wr_cyc(r, c, 4'($urandom));
            else rd_cyc(r, c, "R6 mixed traffic");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule